// File: doc/BRIEF.md
# Flash Write-Completion Status Poller

This block runs a write or erase on a byte-wide flash bank that the host has already selected, and it reports when that operation has finished. A one-cycle `start` pulse captures an operation type, a target address and a data byte. The controller then issues the unlock and command write cycles on a simple synchronous bus. After that it polls the target location with read cycles. It has no ready pin to watch. Completion is judged from status bits inside the read data. The `use_toggle` input selects the method: either the complement-bit check on bit 7 or the alternating-bit check on bit 6.

A read can arrive at the moment the write finishes, so its status may look finished while the rest of the byte has not settled. To avoid a false result, every status read that looks complete is followed by two confirming reads. Each confirming read must show finished status and carry the full expected byte. If either one fails, polling resumes. A counter limits the number of reads. If the limit runs out before completion is confirmed, the block ends the operation with an error pulse.

The bus strobes are registered one for one with controller states. Read data is expected on `bus_rdata` in the cycle after the `bus_rd` strobe. States: `ST_IDLE` waits for a start. `ST_CMD` issues one command write per cycle. `ST_RD` and `ST_EVAL` issue and judge a polling read. `ST_CHK_RD` and `ST_CHK_EVAL` issue and judge the confirming reads. The transitions are: start accepted (IDLE→CMD); final command written (CMD→RD); read issued (RD→EVAL, CHK_RD→CHK_EVAL); status looks done (EVAL→CHK_RD); status not done (EVAL→RD); first confirm good (CHK_EVAL→CHK_RD); second confirm good, so done (CHK_EVAL→IDLE); confirm bad (CHK_EVAL→RD); limit reached on a failed judgement, so error (EVAL/CHK_EVAL→IDLE).

Top module: `flash_poll_ctrl`

## Requirements
- R1: After reset `busy`, `done`, `err`, `bus_wr` and `bus_rd` are all low.
- R2: For op 0 (byte program), the block issues four writes in consecutive cycles: AAh at 5555h, 55h at 2AAAh, A0h at 5555h, then the data byte at the target address.
- R3: For op 1 (sector erase) and op 2 (bank erase), the block issues six consecutive writes: AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh. The last write is 30h at the target address for a sector erase, or 10h at 5555h for a bank erase.
- R4: No read is issued before the final command write. Every read goes to the target address.
- R5: With `use_toggle`=0, a read looks complete when bit 7 equals bit 7 of the data byte (program), or when bit 7 is 1 (erase).
- R6: With `use_toggle`=1, a read looks complete only when its bit 6 equals bit 6 of the read just before it in the same operation.
- R7: After a read that looks complete, two more reads follow. `done` is given only if both still look complete and both return the full expected byte: the data byte for a program, FFh for an erase. A failure of either read resumes polling.
- R8: `done` and `err` are one-cycle pulses. They are never high together, and `busy` is low in the cycle of either pulse.
- R9: When the count of reads in one operation reaches MAX_POLLS and a judgement fails, `err` pulses and no further read is issued.
- R10: A `start` while `busy` is ignored, and so is a `start` with op 3. Neither causes any bus cycle.
- R11: `bus_wr` and `bus_rd` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin an operation |
| op | input | 2 | 0 program, 1 sector erase, 2 bank erase, 3 rejected |
| use_toggle | input | 1 | 1 selects the bit-6 alternation check, 0 the bit-7 check |
| tgt_addr | input | AW | Byte or sector address of the operation |
| wr_byte | input | 8 | Byte to program |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | Completion confirmed (pulse) |
| err | output | 1 | Poll limit ran out (pulse) |
| bus_wr | output | 1 | Write strobe to the command sequencer |
| bus_rd | output | 1 | Read strobe to the command sequencer |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | 8 | Bus write data |
| bus_rdata | input | 8 | Read data, valid the cycle after `bus_rd` |

## Verification
A bench flash model answers with in-progress status for a chosen number of reads and then with final data. After completion it can also return a chosen number of bytes that are still settling: bits 7 and 6 correct, low bits inverted. Programs with bit 7 set and with bit 7 clear show that the complement check follows the data and is not a fixed level. Erases show the bit-7-equals-1 rule, and toggle mode shows that alternation alone is used. Settle counts of one and two show the difference between a confirming read that fails and a poll read that merely looks done: the read totals are B+3 and B+5, where B is the number of in-progress reads. A model that never finishes, together with starts given while busy and with op 3, shows that the read limit holds and that rejected starts cause no bus cycles.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_BANK = 2'd2,
        OP_NONE = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_RD,
        ST_EVAL,
        ST_CHK_RD,
        ST_CHK_EVAL
    } st_e;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;
    localparam logic [2:0] PROG_LAST   = 3'd3;
    localparam logic [2:0] ERASE_LAST  = 3'd5;

endpackage

// File: rtl/fpoll_cmd_rom.sv
module fpoll_cmd_rom
    import flash_poll_pkg::*;
#(
    parameter int unsigned AW = 18
) (
    input  op_e           op,
    input  logic [2:0]    idx,
    input  logic [AW-1:0] tgt,
    input  logic [7:0]    wd,
    output logic [AW-1:0] addr,
    output logic [7:0]    data,
    output logic          last
);
    localparam logic [AW-1:0] UNLOCK_A = AW'(16'h5555);
    localparam logic [AW-1:0] UNLOCK_B = AW'(16'h2AAA);

    always_comb begin
        addr = UNLOCK_A;
        data = 8'hAA;
        last = 1'b0;
        if (op == OP_PROG) begin
            unique case (idx)
                3'd0:    begin addr = UNLOCK_A; data = 8'hAA; end
                3'd1:    begin addr = UNLOCK_B; data = 8'h55; end
                3'd2:    begin addr = UNLOCK_A; data = 8'hA0; end
                default: begin addr = tgt;      data = wd;    end
            endcase
            last = (idx == PROG_LAST);
        end else begin
            unique case (idx)
                3'd0:    begin addr = UNLOCK_A; data = 8'hAA; end
                3'd1:    begin addr = UNLOCK_B; data = 8'h55; end
                3'd2:    begin addr = UNLOCK_A; data = 8'h80; end
                3'd3:    begin addr = UNLOCK_A; data = 8'hAA; end
                3'd4:    begin addr = UNLOCK_B; data = 8'h55; end
                default: begin
                    addr = (op == OP_SECT) ? tgt : UNLOCK_A;
                    data = (op == OP_SECT) ? 8'h30 : 8'h10;
                end
            endcase
            last = (idx == ERASE_LAST);
        end
    end
endmodule

// File: rtl/fpoll_status_eval.sv
module fpoll_status_eval (
    input  logic [7:0] rd,
    input  logic [7:0] exp_byte,
    input  logic       is_prog,
    input  logic       use_toggle,
    input  logic       prev6,
    input  logic       have_prev,
    output logic       status_ok,
    output logic       byte_ok
);
    always_comb begin
        if (use_toggle)   status_ok = have_prev && (rd[6] == prev6);
        else if (is_prog) status_ok = (rd[7] == exp_byte[7]);
        else              status_ok = rd[7];
        byte_ok = (rd == exp_byte);
    end
endmodule

// File: rtl/fpoll_limit.sv
module fpoll_limit #(
    parameter int unsigned MAX_POLLS = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic expired
);
    localparam int unsigned CW = $clog2(MAX_POLLS + 3) + 1;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt_q <= '0;
        else if (clr) cnt_q <= '0;
        else if (inc) cnt_q <= cnt_q + 1'b1;
    end

    assign expired = (cnt_q >= CW'(MAX_POLLS));

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(MAX_POLLS + 2)); // R9
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |=> cnt_q != '0); // R9
endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl
    import flash_poll_pkg::*;
#(
    parameter int unsigned AW        = 18,
    parameter int unsigned MAX_POLLS = 4096
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    op,
    input  logic          use_toggle,
    input  logic [AW-1:0] tgt_addr,
    input  logic [7:0]    wr_byte,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic          bus_wr,
    output logic          bus_rd,
    output logic [AW-1:0] bus_addr,
    output logic [7:0]    bus_wdata,
    input  logic [7:0]    bus_rdata
);
    st_e           st_q, st_d;
    op_e           op_q;
    logic [AW-1:0] tgt_q;
    logic [7:0]    wd_q, exp_q;
    logic          tog_q, prev6_q, have_prev_q, chk_q;
    logic [2:0]    idx_q;
    logic          done_q, err_q;

    logic [AW-1:0] rom_addr;
    logic [7:0]    rom_data;
    logic          rom_last, status_ok, byte_ok, expired;
    logic          accept, judging;

    assign accept  = (st_q == ST_IDLE) && start && (op_e'(op) != OP_NONE);
    assign judging = (st_q == ST_EVAL) || (st_q == ST_CHK_EVAL);

    fpoll_cmd_rom #(.AW(AW)) u_rom (
        .op(op_q), .idx(idx_q), .tgt(tgt_q), .wd(wd_q),
        .addr(rom_addr), .data(rom_data), .last(rom_last)
    );

    fpoll_status_eval u_eval (
        .rd(bus_rdata), .exp_byte(exp_q), .is_prog(op_q == OP_PROG),
        .use_toggle(tog_q), .prev6(prev6_q), .have_prev(have_prev_q),
        .status_ok(status_ok), .byte_ok(byte_ok)
    );

    fpoll_limit #(.MAX_POLLS(MAX_POLLS)) u_limit (
        .clk(clk), .rst_n(rst_n), .clr(accept), .inc(bus_rd),
        .expired(expired)
    );

    // next-state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (accept) st_d = ST_CMD;
            ST_CMD:    if (rom_last) st_d = ST_RD;
            ST_RD:     st_d = ST_EVAL;
            ST_EVAL: begin
                if (status_ok)    st_d = ST_CHK_RD;
                else if (expired) st_d = ST_IDLE;
                else              st_d = ST_RD;
            end
            ST_CHK_RD: st_d = ST_CHK_EVAL;
            ST_CHK_EVAL: begin
                if (status_ok && byte_ok) st_d = chk_q ? ST_IDLE : ST_CHK_RD;
                else if (expired)         st_d = ST_IDLE;
                else                      st_d = ST_RD;
            end
            default:   st_d = ST_IDLE;
        endcase
    end

    // state and context registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            op_q        <= OP_PROG;
            tgt_q       <= '0;
            wd_q        <= '0;
            exp_q       <= '0;
            tog_q       <= 1'b0;
            prev6_q     <= 1'b0;
            have_prev_q <= 1'b0;
            chk_q       <= 1'b0;
            idx_q       <= '0;
            done_q      <= 1'b0;
            err_q       <= 1'b0;
        end else begin
            st_q   <= st_d;
            done_q <= (st_q == ST_CHK_EVAL) && status_ok && byte_ok && chk_q;
            err_q  <= judging && (st_d == ST_IDLE)
                      && !((st_q == ST_CHK_EVAL) && status_ok && byte_ok);
            if (accept) begin
                op_q        <= op_e'(op);
                tgt_q       <= tgt_addr;
                wd_q        <= wr_byte;
                exp_q       <= (op_e'(op) == OP_PROG) ? wr_byte : ERASED_BYTE;
                tog_q       <= use_toggle;
                have_prev_q <= 1'b0;
                idx_q       <= '0;
            end
            if (st_q == ST_CMD) idx_q <= idx_q + 1'b1;
            if (judging) begin
                prev6_q     <= bus_rdata[6];
                have_prev_q <= 1'b1;
            end
            if (st_q == ST_EVAL)          chk_q <= 1'b0;
            else if (st_q == ST_CHK_EVAL) chk_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy      = (st_q != ST_IDLE);
        done      = done_q;
        err       = err_q;
        bus_wr    = (st_q == ST_CMD);
        bus_rd    = (st_q == ST_RD) || (st_q == ST_CHK_RD);
        bus_addr  = (st_q == ST_CMD) ? rom_addr : tgt_q;
        bus_wdata = (st_q == ST_CMD) ? rom_data : 8'h00;
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd)); // R11
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err)); // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |-> !busy); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_RD_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> (bus_addr == tgt_q)); // R4
    AST_CTX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(tgt_q)); // R10
    AST_ERR_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> expired); // R9
endmodule

// File: tb/flash_poll_ctrl_bench.sv
module flash_poll_ctrl_bench;
    localparam int AW = 18;
    localparam int MAXP = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] op = 2'd0;
    logic use_toggle = 1'b0;
    logic [AW-1:0] tgt_addr = '0;
    logic [7:0] wr_byte = 8'h00;
    logic busy, done, err, bus_wr, bus_rd;
    logic [AW-1:0] bus_addr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata = 8'h00;

    always #4 clk = ~clk;

    flash_poll_ctrl #(.AW(AW), .MAX_POLLS(MAXP)) u_flash_poll_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .use_toggle(use_toggle), .tgt_addr(tgt_addr), .wr_byte(wr_byte),
        .busy(busy), .done(done), .err(err), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    int total = 0;
    int bad = 0;

    // flash model
    int m_need = 4, m_busy = 0, m_settle = 0;
    logic m_hang = 1'b0, m_prog = 1'b1;
    logic [7:0] m_exp = 8'h00;
    int n_wr = 0, n_rd = 0, pre_rd = 0, busy_left = 0, post = 0;
    logic tog = 1'b0;
    logic [AW-1:0] wa [0:7];
    logic [7:0] wd [0:7];

    always @(posedge clk) begin
        if (bus_wr) begin
            if (n_wr < 8) begin
                wa[n_wr] <= bus_addr;
                wd[n_wr] <= bus_wdata;
            end
            n_wr <= n_wr + 1;
            if (n_wr + 1 == m_need) begin
                busy_left <= m_busy;
                post <= 0;
                tog <= 1'b0;
            end
        end
        if (bus_rd) begin
            n_rd <= n_rd + 1;
            if (n_wr < m_need) pre_rd <= pre_rd + 1;
            if (m_hang || busy_left > 0) begin
                busy_left <= busy_left - 1;
                bus_rdata <= {(m_prog ? ~m_exp[7] : 1'b0), tog, 6'b0};
                tog <= ~tog;
            end else begin
                post <= post + 1;
                if (post < m_settle) bus_rdata <= {m_exp[7:6], ~m_exp[5:0]};
                else                 bus_rdata <= m_exp;
            end
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog: actual=%0d expected<=150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int expv);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    logic got_done, got_err;

    task automatic arm(input logic [1:0] o, input logic tm, input logic [AW-1:0] a,
                       input logic [7:0] d, input int b, input int s, input logic h);
        @(negedge clk);
        m_need = (o == 2'd0) ? 4 : 6;
        m_prog = (o == 2'd0);
        m_exp = (o == 2'd0) ? d : 8'hFF;
        m_busy = b; m_settle = s; m_hang = h;
        n_wr = 0; n_rd = 0; pre_rd = 0;
        op = o; use_toggle = tm; tgt_addr = a; wr_byte = d;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_end();
        got_done = 1'b0; got_err = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            if (done || err) break;
            @(negedge clk);
        end
        got_done = done; got_err = err;
        chk(!busy, "R8", "busy during end pulse", busy, 0);
        @(negedge clk);
        chk(!done && !err, "R8", "pulse width", done | err, 0);
    endtask

    task automatic check_seq(input logic [1:0] o, input logic [AW-1:0] a, input logic [7:0] d);
        logic [AW-1:0] ea [0:5];
        logic [7:0] ed [0:5];
        int n;
        string r;
        r = (o == 2'd0) ? "R2" : "R3";
        ea[0] = 'h5555; ed[0] = 8'hAA;
        ea[1] = 'h2AAA; ed[1] = 8'h55;
        ea[2] = 'h5555;
        if (o == 2'd0) begin
            n = 4; ed[2] = 8'hA0; ea[3] = a; ed[3] = d;
        end else begin
            n = 6; ed[2] = 8'h80;
            ea[3] = 'h5555; ed[3] = 8'hAA;
            ea[4] = 'h2AAA; ed[4] = 8'h55;
            ea[5] = (o == 2'd1) ? a : 'h5555;
            ed[5] = (o == 2'd1) ? 8'h30 : 8'h10;
        end
        chk(n_wr == n, r, "write count", n_wr, n);
        for (int k = 0; k < n; k++) begin
            chk(wa[k] == ea[k], r, "write addr", int'(wa[k]), int'(ea[k]));
            chk(wd[k] == ed[k], r, "write data", int'(wd[k]), int'(ed[k]));
        end
        chk(pre_rd == 0, "R4", "reads before last command", pre_rd, 0);
    endtask

    task automatic t_reset();
        chk(!busy && !done && !err, "R1", "status after reset", {busy, done, err}, 0);
        chk(!bus_wr && !bus_rd, "R1", "strobes after reset", {bus_wr, bus_rd}, 0);
    endtask

    task automatic t_prog_data_hi();
        arm(2'd0, 1'b0, 18'h1_2345, 8'hA7, 6, 0, 1'b0);
        wait_end();
        check_seq(2'd0, 18'h1_2345, 8'hA7);
        chk(got_done && !got_err, "R5", "program bit7=1 done", got_done, 1);
        chk(n_rd == 9, "R7", "reads program no settle", n_rd, 9);
    endtask

    task automatic t_prog_data_lo();
        arm(2'd0, 1'b0, 18'h0_0F0F, 8'h3C, 5, 1, 1'b0);
        wait_end();
        chk(got_done, "R5", "program bit7=0 done", got_done, 1);
        chk(n_rd == 8, "R7", "reads settle 1 (confirm catches late bits)", n_rd, 8);
    endtask

    task automatic t_prog_settle2();
        arm(2'd0, 1'b0, 18'h2_0001, 8'h96, 4, 2, 1'b0);
        wait_end();
        chk(got_done, "R7", "done after failed confirm", got_done, 1);
        chk(n_rd == 9, "R7", "reads settle 2 (resumes polling)", n_rd, 9);
    endtask

    task automatic t_sector();
        arm(2'd1, 1'b0, 18'h3_7000, 8'h00, 7, 0, 1'b0);
        wait_end();
        check_seq(2'd1, 18'h3_7000, 8'h00);
        chk(got_done, "R5", "sector erase bit7 rule", got_done, 1);
        chk(n_rd == 10, "R5", "sector erase read count", n_rd, 10);
    endtask

    task automatic t_bank_toggle();
        arm(2'd2, 1'b1, 18'h0_4000, 8'h00, 8, 0, 1'b0);
        wait_end();
        check_seq(2'd2, 18'h0_4000, 8'h00);
        chk(got_done, "R6", "bank erase toggle done", got_done, 1);
        chk(n_rd >= 11 && n_rd <= 12, "R6", "toggle read count", n_rd, 11);
    endtask

    task automatic t_prog_toggle();
        arm(2'd0, 1'b1, 18'h1_1111, 8'h3C, 9, 1, 1'b0);
        wait_end();
        chk(got_done, "R6", "program toggle done", got_done, 1);
        chk(n_rd >= 12 && n_rd <= 14, "R6", "toggle settle read count", n_rd, 12);
    endtask

    task automatic t_timeout();
        arm(2'd0, 1'b0, 18'h0_0123, 8'h55, 0, 0, 1'b1);
        wait_end();
        chk(got_err && !got_done, "R9", "err on hang", got_err, 1);
        chk(n_rd == MAXP, "R9", "reads at limit", n_rd, MAXP);
        repeat (10) @(negedge clk);
        chk(n_rd == MAXP, "R9", "no reads after err", n_rd, MAXP);
        arm(2'd1, 1'b1, 18'h0_5000, 8'h00, 0, 0, 1'b1);
        wait_end();
        chk(got_err && n_rd == MAXP, "R9", "toggle hang err reads", n_rd, MAXP);
    endtask

    task automatic t_busy_start();
        arm(2'd0, 1'b0, 18'h0_0777, 8'h81, 10, 0, 1'b0);
        repeat (3) @(negedge clk);
        op = 2'd2; tgt_addr = 18'h3_FFFF; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_end();
        chk(n_wr == 4, "R10", "writes after busy start", n_wr, 4);
        chk(wa[3] == 18'h0_0777, "R10", "target kept", int'(wa[3]), 'h777);
        chk(got_done && n_rd == 13, "R10", "op unaffected", n_rd, 13);
    endtask

    task automatic t_bad_op();
        arm(2'd3, 1'b0, 18'h0_0001, 8'h11, 0, 0, 1'b0);
        repeat (6) @(negedge clk);
        chk(!busy, "R10", "op 3 busy", busy, 0);
        chk(n_wr == 0 && n_rd == 0, "R10", "op 3 bus cycles", n_wr + n_rd, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_prog_data_hi();
        t_prog_data_lo();
        t_prog_settle2();
        t_sector();
        t_bank_toggle();
        t_prog_toggle();
        t_timeout();
        t_busy_start();
        t_bad_op();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule